// File: doc/BRIEF.md
# MDIO Management Command Master

This block carries out single clause-22 management transactions towards an external Ethernet PHY. Software hands it one 32-bit command word that holds a start flag, a direction flag, a 5-bit PHY address, a 5-bit register address and 16 data bits. The block then clocks a complete management frame out on MDC/MDIO.

While a frame is in progress, bit 31 of the same word reads back as 1. Software polls that bit until it clears. After a read, the low 16 bits of the word hold the value returned by the PHY.

MDC comes from the system clock through an even divider, `CLK_DIV`. Its default of 20 gives 2.5 MHz from a 50 MHz clock. The master changes MDIO while MDC is low, so each bit is stable around the rising MDC edge, and it samples returned data on that rising edge.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset, `cmd_rdata` is 0, `mdc` is 0 and `mdio_oe` is 0.
- R2: A write of `cmd_wdata` with bit 31 = 1 while bit 31 of `cmd_rdata` is 0 starts a frame. From the next cycle, bit 31 of `cmd_rdata` reads 1. It clears in the cycle of the falling MDC edge that ends the 64th bit, which comes after exactly 64 MDC periods.
- R3: Each frame is sent MSB first as follows: 32 ones, the start pattern 01, an opcode, the PHY address from bits 25:21, and the register address from bits 20:16. The opcode is 10 when bit 30 = 1 (read) and 01 when bit 30 = 0 (write).
- R4: On a write (bit 30 = 0), the address fields are followed by the turnaround bits 10 and then data bits 15:0. `mdio_oe` stays 1 for all 64 bits.
- R5: On a read, `mdio_oe` is 0 from the first turnaround bit (bit 46 of the frame) to the end of the frame. `mdio_i` is sampled on the rising MDC edges of bits 48..63. When bit 31 clears, `cmd_rdata[15:0]` holds the captured value, MSB first, and bits 30:16 keep the written values.
- R6: MDC has a period of `CLK_DIV` system clocks with equal high and low halves. It stays 0 while no frame is running.
- R7: Writes made while bit 31 reads 1 are ignored: the frame on the wire and the final register contents do not change.
- R8: A write with bit 31 = 0 while idle stores bits 30:0 in the register without starting a frame.
- R9: `mdio_oe` and `mdio_o` are 0 whenever no frame is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command word to write |
| cmd_rdata | output | 32 | Command register read-back (busy in bit 31) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |
| mdio_i | input | 1 | MDIO value seen on the pin |

## Verification
The bench builds the block with `CLK_DIV` = 4, so each frame takes 256 system clocks. This lets several complete reads and writes, including a write collision mid-frame, fit in a short run while still exercising a divider with separate high and low halves. A PHY model in the bench answers reads and drives 0 on the second turnaround bit. Frames are compared bit by bit, and the enable pattern is checked together with them.

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master #(
  parameter int CLK_DIV = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] cmd_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int HALF     = CLK_DIV / 2;
  localparam int CW       = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int LAST_BIT = 63;
  localparam int TA_BIT   = 46;
  localparam int DAT_BIT  = 48;

  logic [31:0]   cmd;
  logic [CW-1:0] cnt;
  logic [5:0]    bidx;
  logic          mdc_q;

  wire busy  = cmd[31];
  wire is_rd = cmd[30];
  wire tick  = busy && (cnt == CW'(HALF - 1));

  wire [63:0] frame = {32'hFFFF_FFFF, 2'b01, (is_rd ? 2'b10 : 2'b01),
                       cmd[25:21], cmd[20:16], 2'b10, cmd[15:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd   <= '0;
      cnt   <= '0;
      bidx  <= '0;
      mdc_q <= 1'b0;
    end else if (!busy) begin
      cnt   <= '0;
      bidx  <= '0;
      mdc_q <= 1'b0;
      if (cmd_we) cmd <= cmd_wdata;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick) begin
        mdc_q <= ~mdc_q;
        if (!mdc_q) begin
          if (is_rd && bidx >= 6'(DAT_BIT)) cmd[15:0] <= {cmd[14:0], mdio_i};
        end else if (bidx == 6'(LAST_BIT)) begin
          cmd[31] <= 1'b0;
        end else begin
          bidx <= bidx + 1'b1;
        end
      end
    end
  end

  assign cmd_rdata = cmd;
  assign mdc       = mdc_q;
  assign mdio_oe   = busy && (!is_rd || bidx < 6'(TA_BIT));
  assign mdio_o    = mdio_oe && frame[6'd63 - bidx];
endmodule

module mdio_cmd_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_we,
  input logic [31:0] cmd_wdata,
  input logic [31:0] cmd_rdata,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_rdata[31] && cmd_we && cmd_wdata[31]) |=> cmd_rdata[31]);

  p_fields_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rdata[31] && $past(cmd_rdata[31])) |-> $stable(cmd_rdata[30:16]));

  p_mdc_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_rdata[31] |-> !mdc);

  p_oe_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_rdata[31] |-> (!mdio_oe && !mdio_o));

  p_no_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_rdata[31] && cmd_we && !cmd_wdata[31]) |=> !cmd_rdata[31]);
endmodule

bind mdio_cmd_master mdio_cmd_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
  .cmd_rdata(cmd_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_cmd_master_tb.sv
module mdio_cmd_master_tb;
  localparam int DIV = 4;

  typedef struct {
    logic [63:0] bits;
    logic [63:0] oe;
    logic [31:0] rdata;
  } exp_t;

  logic        clk = 0, rst_n = 0, cmd_we = 0, mdio_i = 1;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] cmd_rdata;
  logic        mdc, mdio_o, mdio_oe;

  int   n_chk = 0, n_err = 0, n_done = 0, falls = 0;
  logic        cur_rd = 0;
  logic [15:0] phy_val = '0;
  exp_t q[$];

  mdio_cmd_master #(.CLK_DIV(DIV)) u_dut (.*);

  always #10 clk = ~clk;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // PHY model: drive the next bit after each falling MDC edge
  always @(negedge mdc) begin
    #1;
    falls = (falls + 1) % 64;
    if (cur_rd && falls >= 48) mdio_i = phy_val[63 - falls];
    else if (cur_rd && falls == 47) mdio_i = 1'b0;
    else mdio_i = 1'b1;
  end

  // monitor
  initial begin
    forever begin
      logic [63:0] got, goe;
      logic busy_ok;
      realtime t0, t1;
      exp_t e;
      busy_ok = 1;
      for (int k = 0; k < 64; k++) begin
        @(posedge mdc);
        if (k == 0) t0 = $realtime;
        if (k == 1) t1 = $realtime;
        #1;
        got[63-k] = mdio_o;
        goe[63-k] = mdio_oe;
        if (!cmd_rdata[31]) busy_ok = 0;
      end
      @(negedge mdc);
      #1;
      e = q.pop_front();
      chk("R3/R4/R5 frame", got & e.oe, e.bits & e.oe);
      chk("R4/R5 oe", goe, e.oe);
      chk("R2 busy during frame", 64'(busy_ok), 64'd1);
      chk("R6 mdc period", 64'(int'(t1 - t0)), 64'(DIV * 20));
      chk("R2/R5 rdata after frame", 64'(cmd_rdata), 64'(e.rdata));
      chk("R9 oe idle", {mdio_oe, mdio_o}, 2'b00);
      n_done++;
    end
  end

  task automatic wr(logic [31:0] w);
    @(negedge clk);
    cmd_wdata = w; cmd_we = 1;
    @(negedge clk);
    cmd_we = 0;
  endtask

  task automatic run(logic rd, logic [4:0] pa, logic [4:0] ra, logic [15:0] d,
                     logic [15:0] pv, logic poke);
    exp_t e;
    logic [31:0] w;
    int target;
    w = {1'b1, rd, 4'b0, pa, ra, d};
    e.bits = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), pa, ra, 2'b10, d};
    e.oe = rd ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
    e.rdata = rd ? {1'b0, w[30:16], pv} : {1'b0, w[30:0]};
    q.push_back(e);
    cur_rd = rd; phy_val = pv; falls = 0;
    target = n_done + 1;
    wr(w);
    if (poke) begin
      repeat (100) @(negedge clk);
      wr(~w);  // R7: must be ignored
    end
    wait (n_done == target);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #10000000;
    n_err++; n_chk++;
    $display("FAIL watchdog act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rdata", 64'(cmd_rdata), 64'd0);
    chk("R1 mdc/oe", {mdc, mdio_oe}, 2'b00);
    rst_n = 1;
    repeat (2) @(negedge clk);
    run(0, 5'h01, 5'h00, 16'hA55A, 16'h0, 0);
    run(1, 5'h1F, 5'h02, 16'h0000, 16'hC3E1, 0);
    run(0, 5'h12, 5'h1B, 16'h8001, 16'h0, 1);
    run(1, 5'h00, 5'h1F, 16'hFFFF, 16'h7E18, 1);
    // R8: store without start
    wr(32'h2345_6789);
    repeat (2 * DIV) @(negedge clk);
    chk("R8 stored", 64'(cmd_rdata), 64'h2345_6789);
    chk("R8 no frame mdc", {mdc, mdio_oe}, 2'b00);
    chk("R9 idle outputs", {mdio_oe, mdio_o}, 2'b00);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule